// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard controller of a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Each cycle it looks at the register numbers and control bits held in the four pipeline registers. From them it produces the operand source selects for the two ALU inputs, a forward select for the zero-test comparator in decode, and hold signals for the program counter and the fetch/decode register. It also drives a bubble into the decode/execute register and a squash of the instruction fetched behind a taken branch.

Sources are read in decode and results are written in write-back, so only read-after-write dependences need handling. The register file is assumed to write before it reads within a cycle. A value that is in write-back therefore reaches decode through the register file, and the block only forwards from the memory stage into decode. Branches compare one register against zero in decode. Fetch always continues sequentially, and a taken branch costs one squashed slot. The block is purely combinational. The clock and reset are used only by its embedded properties.

Top module: `phz_hazard_unit`

## Requirements
- R1: When the memory-stage producer has write enable set, a nonzero destination and a destination equal to an execute-stage source, that operand's select is 2'b10.
- R2: When only the write-back producer matches an execute-stage source under the same conditions, the select is 2'b01. With no match the select is 2'b00, meaning the register file.
- R3: When both the memory-stage and write-back producers match the same source, the select is 2'b10, so the younger result wins.
- R4: A destination of register 0 never produces a nonzero select, a stall or a decode forward.
- R5: A producer whose write enable is low is never forwarded from and never causes a stall.
- R6: A load in execute whose nonzero destination equals a decode source that the decode instruction uses sets pc_hold, ifid_hold and idex_bubble together for that cycle. A matching field that is not used causes no stall.
- R7: A branch in decode stalls when its tested register is the destination of any writing instruction in execute, or of a load in the memory stage.
- R8: id_cmp_fwd is 1 when a non-load writing instruction in the memory stage has a nonzero destination equal to the decode source. A branch in that situation does not stall.
- R9: ifid_flush is 1 exactly when a branch in decode is taken and no stall is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded properties |
| rst_n | input | 1 | Active-low reset, used only by the embedded properties |
| id_rs | input | AW | First source register of the decode instruction |
| id_rt | input | AW | Second source register of the decode instruction |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| id_branch | input | 1 | Decode instruction is a zero-test branch on id_rs |
| id_br_taken | input | 1 | Comparator result in decode: the branch condition holds |
| ex_rs | input | AW | First source register of the execute instruction |
| ex_rt | input | AW | Second source register of the execute instruction |
| ex_rd | input | AW | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination register in the memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | AW | Destination register in write-back |
| wb_wen | input | 1 | Write-back instruction writes a register |
| opa_sel | output | 2 | Source select for ALU operand A: 00 register file, 01 write-back, 10 memory stage |
| opb_sel | output | 2 | Source select for ALU operand B, same encoding |
| id_cmp_fwd | output | 1 | Feed the zero-test comparator from the memory-stage result |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| ifid_flush | output | 1 | Turn the fetch/decode register into a bubble |

## Verification
Two functions can meet in one cycle. A branch in decode may be taken while a stall is also raised, and the flush must then stay low. An operand may also match both producers at once, and the memory-stage result must then win. The bench provokes both by replaying short programs through its own pipeline model. One program places a taken branch directly behind the ALU instruction that writes its tested register. Another places two back-to-back writes to the same register before a consumer. In each case the bench compares the stall, flush and select outputs cycle by cycle against values derived from the stage contents it holds itself.

// File: rtl/phz_pkg.sv
package phz_pkg;
  // Operand source encoding shared by the select logic and the top.
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } opsrc_e;
endpackage

// File: rtl/phz_fwd_select.sv
module phz_fwd_select
  import phz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output opsrc_e        sel,
  output logic          mem_hit,
  output logic          wb_hit
);
  // A producer counts only if it writes, targets a real register and matches.
  function automatic logic prod_hit(input logic [AW-1:0] rd, input logic wen,
                                    input logic [AW-1:0] s);
    return wen && (rd != '0) && (rd == s);
  endfunction

  assign mem_hit = prod_hit(mem_rd, mem_wen, src);
  assign wb_hit  = prod_hit(wb_rd, wb_wen, src);

  // The younger memory-stage result outranks write-back.
  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SRC_RF));  // R4
  AST_MEM_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_MEM) |-> mem_wen);  // R5
  AST_WB_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_WB) |-> wb_wen);  // R5
endmodule

// File: rtl/phz_loaduse.sv
module phz_loaduse #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  output logic          lu_hit
);
  logic load_live;
  logic rs_dep;
  logic rt_dep;

  assign load_live = ex_load && ex_wen && (ex_rd != '0);
  assign rs_dep    = id_use_rs && (id_rs == ex_rd);
  assign rt_dep    = id_use_rt && (id_rt == ex_rd);
  assign lu_hit    = load_live && (rs_dep || rt_dep);

  AST_LU_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lu_hit |-> (ex_load && ex_wen));  // R6
endmodule

// File: rtl/phz_branch_ctl.sv
module phz_branch_ctl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic          id_branch,
  input  logic          id_br_taken,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic          other_stall,
  output logic          br_stall,
  output logic          cmp_fwd,
  output logic          flush
);
  logic ex_pending;
  logic mem_load_pending;

  // Value still in execute, or a load still reading memory: not yet available.
  assign ex_pending       = ex_wen && (ex_rd != '0) && (ex_rd == id_rs);
  assign mem_load_pending = mem_load && mem_wen && (mem_rd != '0) && (mem_rd == id_rs);
  assign br_stall         = id_branch && (ex_pending || mem_load_pending);

  // A finished ALU result in the memory stage can feed the comparator.
  assign cmp_fwd = mem_wen && !mem_load && (mem_rd != '0) && (mem_rd == id_rs);

  assign flush = id_branch && id_br_taken && !br_stall && !other_stall;

  AST_CMP_FWD_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fwd |-> !mem_load);  // R8
  AST_STALLED_BR_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    br_stall |-> !flush);  // R9
endmodule

// File: rtl/phz_hazard_unit.sv
module phz_hazard_unit
  import phz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic          id_branch,
  input  logic          id_br_taken,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    opa_sel,
  output logic [1:0]    opb_sel,
  output logic          id_cmp_fwd,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_flush
);
  localparam int NOPS = 2;

  logic [AW-1:0] op_src  [NOPS];
  opsrc_e        op_sel  [NOPS];
  logic          op_mhit [NOPS];
  logic          op_whit [NOPS];

  assign op_src[0] = ex_rs;
  assign op_src[1] = ex_rt;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    phz_fwd_select #(.AW(AW)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (op_src[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (op_sel[g]),
      .mem_hit (op_mhit[g]),
      .wb_hit  (op_whit[g])
    );
  end

  assign opa_sel = op_sel[0];
  assign opb_sel = op_sel[1];

  logic lu_hit;
  logic br_stall;
  logic br_flush;
  logic stall_any;

  phz_loaduse #(.AW(AW)) u_lu (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .id_use_rs (id_use_rs),
    .id_use_rt (id_use_rt),
    .ex_rd     (ex_rd),
    .ex_wen    (ex_wen),
    .ex_load   (ex_load),
    .lu_hit    (lu_hit)
  );

  phz_branch_ctl #(.AW(AW)) u_br (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_rs       (id_rs),
    .id_branch   (id_branch),
    .id_br_taken (id_br_taken),
    .ex_rd       (ex_rd),
    .ex_wen      (ex_wen),
    .mem_rd      (mem_rd),
    .mem_wen     (mem_wen),
    .mem_load    (mem_load),
    .other_stall (lu_hit),
    .br_stall    (br_stall),
    .cmp_fwd     (id_cmp_fwd),
    .flush       (br_flush)
  );

  assign stall_any   = lu_hit || br_stall;
  assign pc_hold     = stall_any;
  assign ifid_hold   = stall_any;
  assign idex_bubble = stall_any;
  assign ifid_flush  = br_flush;

  AST_LOADUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lu_hit |-> (pc_hold && ifid_hold && idex_bubble));  // R6
  AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    br_stall |-> (pc_hold && idex_bubble));  // R7
  AST_FLUSH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> !pc_hold);  // R9
  AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mhit[0] && op_whit[0]) |-> (opa_sel == 2'b10));  // R3
endmodule

// File: tb/phz_hazard_unit_tb.sv
module phz_hazard_unit_tb_top;
  localparam int AW = 5;
  localparam int K_NOP = 0, K_ALU = 1, K_LD = 2, K_ST = 3, K_BR = 4;

  typedef struct {
    int kind;
    int rd;
    int rs;
    int rt;
    bit tk;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_use_rs, id_use_rt, id_branch, id_br_taken;
  logic ex_wen, ex_load, mem_wen, mem_load, wb_wen;
  logic [1:0] opa_sel, opb_sel;
  logic id_cmp_fwd, pc_hold, ifid_hold, idex_bubble, ifid_flush;

  phz_hazard_unit #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
    .id_branch(id_branch), .id_br_taken(id_br_taken),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
    .wb_rd(wb_rd), .wb_wen(wb_wen),
    .opa_sel(opa_sel), .opb_sel(opb_sel), .id_cmp_fwd(id_cmp_fwd),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  ins_t prog[$];
  ins_t s_id, s_ex, s_mem, s_wb;
  int pc;

  function automatic ins_t mk(int kind, int rd, int rs, int rt, bit tk);
    ins_t r;
    r.kind = kind; r.rd = rd; r.rs = rs; r.rt = rt; r.tk = tk;
    return r;
  endfunction

  function automatic bit writes(ins_t i);
    return (i.kind == K_ALU) || (i.kind == K_LD);
  endfunction
  function automatic bit reads_rs(ins_t i);
    return i.kind != K_NOP;
  endfunction
  function automatic bit reads_rt(ins_t i);
    return (i.kind == K_ALU) || (i.kind == K_ST);
  endfunction

  // Reference: scan producers youngest first; the first real match decides.
  function automatic int ref_src(int src);
    ins_t pr[2];
    pr[0] = s_mem;
    pr[1] = s_wb;
    for (int k = 0; k < 2; k++) begin
      if (src != 0 && writes(pr[k]) && pr[k].rd == src) return (k == 0) ? 2 : 1;
    end
    return 0;
  endfunction

  function automatic bit ref_loaduse();
    if (s_ex.kind != K_LD || s_ex.rd == 0) return 1'b0;
    return (reads_rs(s_id) && s_id.rs == s_ex.rd) || (reads_rt(s_id) && s_id.rt == s_ex.rd);
  endfunction

  function automatic bit ref_brstall();
    if (s_id.kind != K_BR || s_id.rs == 0) return 1'b0;
    if (writes(s_ex) && s_ex.rd == s_id.rs) return 1'b1;
    return (s_mem.kind == K_LD) && (s_mem.rd == s_id.rs);
  endfunction

  function automatic bit ref_cmpfwd();
    return (s_mem.kind == K_ALU) && (s_mem.rd != 0) && (s_mem.rd == s_id.rs);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic drive();
    id_rs       = AW'(s_id.rs);
    id_rt       = AW'(s_id.rt);
    id_use_rs   = reads_rs(s_id);
    id_use_rt   = reads_rt(s_id);
    id_branch   = (s_id.kind == K_BR);
    id_br_taken = s_id.tk;
    ex_rs       = AW'(s_ex.rs);
    ex_rt       = AW'(s_ex.rt);
    ex_rd       = AW'(s_ex.rd);
    ex_wen      = writes(s_ex);
    ex_load     = (s_ex.kind == K_LD);
    mem_rd      = AW'(s_mem.rd);
    mem_wen     = writes(s_mem);
    mem_load    = (s_mem.kind == K_LD);
    wb_rd       = AW'(s_wb.rd);
    wb_wen      = writes(s_wb);
  endtask

  task automatic run_prog(string name);
    ins_t nop;
    bit st, fl;
    nop = mk(K_NOP, 0, 0, 0, 1'b0);
    s_id = nop; s_ex = nop; s_mem = nop; s_wb = nop;
    pc = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      drive();
      @(negedge clk);
      st = ref_loaduse() || ref_brstall();
      fl = (s_id.kind == K_BR) && s_id.tk && !st;
      chk("R1 R2 R3 R4 R5", {name, " opa_sel"}, int'(opa_sel), ref_src(s_ex.rs));
      chk("R1 R2 R3 R4 R5", {name, " opb_sel"}, int'(opb_sel), ref_src(s_ex.rt));
      chk("R8", {name, " id_cmp_fwd"}, int'(id_cmp_fwd), int'(ref_cmpfwd()));
      chk("R6 R7", {name, " pc_hold"}, int'(pc_hold), int'(st));
      chk("R6 R7", {name, " ifid_hold"}, int'(ifid_hold), int'(st));
      chk("R6 R7", {name, " idex_bubble"}, int'(idex_bubble), int'(st));
      chk("R9", {name, " ifid_flush"}, int'(ifid_flush), int'(fl));
      // Advance the bench's own pipeline.
      s_wb = s_mem;
      s_mem = s_ex;
      if (st) begin
        s_ex = nop;
      end else begin
        s_ex = s_id;
        if (pc < prog.size()) begin
          s_id = fl ? nop : prog[pc];
          pc++;
        end else begin
          s_id = nop;
        end
      end
      @(posedge clk);
      #1;
      if (pc >= prog.size() && s_id.kind == K_NOP && s_ex.kind == K_NOP &&
          s_mem.kind == K_NOP && s_wb.kind == K_NOP) break;
    end
    prog.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    s_id = mk(K_NOP, 0, 0, 0, 1'b0);
    s_ex = s_id; s_mem = s_id; s_wb = s_id;
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: idle pipeline gives register-file selects and no control.
    chk("R2", "reset opa_sel", int'(opa_sel), 0);
    chk("R2", "reset opb_sel", int'(opb_sel), 0);
    chk("R6", "reset pc_hold", int'(pc_hold), 0);
    chk("R9", "reset ifid_flush", int'(ifid_flush), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R1 R2: producer followed by four dependent uses.
    prog.push_back(mk(K_ALU, 1, 2, 3, 0));
    prog.push_back(mk(K_ALU, 4, 1, 3, 0));
    prog.push_back(mk(K_ALU, 6, 1, 7, 0));
    prog.push_back(mk(K_ALU, 8, 9, 1, 0));
    prog.push_back(mk(K_ALU, 10, 1, 11, 0));
    run_prog("alu_chain");

    // R3: two writes to r5, then a consumer sees both in flight.
    prog.push_back(mk(K_ALU, 5, 2, 3, 0));
    prog.push_back(mk(K_ALU, 5, 6, 7, 0));
    prog.push_back(mk(K_ALU, 7, 5, 5, 0));
    run_prog("both_match");

    // R6: load then dependent use (rs and rt), plus unused-field case.
    prog.push_back(mk(K_LD, 1, 2, 0, 0));
    prog.push_back(mk(K_ALU, 4, 1, 6, 0));
    prog.push_back(mk(K_LD, 3, 2, 0, 0));
    prog.push_back(mk(K_ALU, 8, 9, 3, 0));
    prog.push_back(mk(K_LD, 12, 2, 0, 0));
    prog.push_back(mk(K_LD, 13, 14, 12, 0));
    run_prog("load_use");

    // R4: destination r0 must neither forward nor stall.
    prog.push_back(mk(K_ALU, 0, 2, 3, 0));
    prog.push_back(mk(K_ALU, 2, 0, 0, 0));
    prog.push_back(mk(K_LD, 0, 2, 0, 0));
    prog.push_back(mk(K_ALU, 3, 0, 0, 0));
    prog.push_back(mk(K_ALU, 0, 1, 1, 0));
    prog.push_back(mk(K_BR, 0, 0, 0, 1));
    prog.push_back(mk(K_ALU, 9, 9, 9, 0));
    prog.push_back(mk(K_ALU, 10, 1, 1, 0));
    run_prog("reg_zero");

    // R5: store carries a destination field but does not write.
    prog.push_back(mk(K_ST, 4, 1, 2, 0));
    prog.push_back(mk(K_ALU, 5, 4, 4, 0));
    prog.push_back(mk(K_ALU, 6, 4, 4, 0));
    prog.push_back(mk(K_BR, 0, 4, 0, 0));
    run_prog("no_wen");

    // R7 R8 R9: taken branch right behind its producer.
    prog.push_back(mk(K_ALU, 1, 2, 3, 0));
    prog.push_back(mk(K_BR, 0, 1, 0, 1));
    prog.push_back(mk(K_ALU, 9, 9, 9, 0));
    prog.push_back(mk(K_ALU, 10, 1, 1, 0));
    run_prog("taken_branch");

    // R7: branch on a loaded register waits two cycles; not taken.
    prog.push_back(mk(K_LD, 2, 3, 0, 0));
    prog.push_back(mk(K_BR, 0, 2, 0, 0));
    prog.push_back(mk(K_ALU, 4, 2, 2, 0));
    run_prog("load_branch");

    // R9 with R8: forwarded compare, taken, one instruction gap.
    prog.push_back(mk(K_ALU, 7, 2, 3, 0));
    prog.push_back(mk(K_ALU, 8, 2, 3, 0));
    prog.push_back(mk(K_BR, 0, 7, 0, 1));
    prog.push_back(mk(K_ALU, 11, 11, 11, 0));
    prog.push_back(mk(K_ALU, 12, 7, 8, 0));
    run_prog("fwd_branch");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule